// File: doc/BRIEF.md
# Oversampling Serial Receiver with Address Filter

This block takes in characters from an asynchronous serial line. It relies on a sample strobe that pulses sixteen times per bit period. When the line falls, the block treats the fall as a possible start bit. It confirms the start bit at the middle of the bit, then samples each data bit at its midpoint. Characters are 8 or 9 bits long. An optional parity bit is checked in 8-bit mode, and the first stop bit is checked as well. Each finished character is written, with its error flags, into a four-entry first-in first-out queue. Consumer logic reads the queue with a pop strobe.

In 9-bit mode, an address filter can drop every character whose ninth bit is clear. A node on a multidrop bus then sees only address characters. When a character finishes and the queue is already full, the character is lost and a sticky overrun flag is raised. A ready-to-receive output goes low while the queue holds three or more words, so the far end can pause. A loopback select replaces the external receive line with a local transmit line, for self-test.

Top module: `uart_rx_top`

## Requirements
- R1: After a falling edge is seen on a strobe, the block samples the line again on the 8th strobe that follows. If the line is high there, the block returns to idle and stores nothing.
- R2: In 8-bit mode, the data bits arrive least significant bit first and are each sampled 16 strobes apart. They are stored in `rdData[7:0]`, and `rdData[8]` reads 0.
- R3: When `nineBit`=1, nine data bits are received and stored in `rdData[8:0]`. No parity bit is expected, and `rdParErr` is 0 whatever `parityMode` holds.
- R4: In 8-bit mode, `parityMode` selects the parity check: 2'b00 none, 2'b01 even, 2'b10 odd, 2'b11 none. If the parity bit after the data does not match the selected sense, the stored entry carries `rdParErr`=1.
- R5: If the first stop bit is sampled low, the character is still stored, and its entry carries `rdFrmErr`=1.
- R6: With `nineBit`=1 and `addrOnly`=1, a character whose ninth bit is 0 is discarded. A character whose ninth bit is 1 is stored.
- R7: Stored entries are read in arrival order. `rdValid` is high whenever `level` is above 0, and a `popReq` pulse removes the head entry and lowers `level` by one.
- R8: A character that finishes while `level` is 4 is discarded, and `overrun` is set. `overrun` stays set until an `ovrClear` pulse arrives.
- R9: `sendReq` is 0 while `level` is 3 or more, and 1 while `level` is below 3.
- R10: With `loopEn`=1, the receiver takes its line from `txLoop` and ignores `rxIn`. With `loopEn`=0, it takes its line from `rxIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| sampleTick | input | 1 | Strobe at 16x the bit rate |
| rxIn | input | 1 | External receive line |
| txLoop | input | 1 | Local transmit line used in loopback |
| loopEn | input | 1 | Selects txLoop as the receive source |
| nineBit | input | 1 | 9-bit character mode |
| parityMode | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| addrOnly | input | 1 | Keep only characters with ninth bit set (9-bit mode) |
| popReq | input | 1 | Remove the head entry |
| ovrClear | input | 1 | Clear the overrun flag |
| rdData | output | 9 | Head entry data |
| rdParErr | output | 1 | Head entry parity error |
| rdFrmErr | output | 1 | Head entry framing error |
| rdValid | output | 1 | Queue not empty |
| level | output | 3 | Number of stored entries |
| overrun | output | 1 | Sticky lost-character flag |
| sendReq | output | 1 | Ready to receive (flow control) |

## Verification
A change on the line passes through a two-stage synchronizer. Sampling then happens on a strobe, and the queue write follows one clock after the stop-bit midpoint strobe. `level`, `rdValid`, `sendReq` and the head fields therefore change about 8 strobes into the stop bit. The bench holds the line idle for 20 further strobes before it samples any of these outputs, so every result is settled well before it is read. Pops and overrun clears take effect on the next edge, and the bench reads their results at the following falling clock edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF  = 2'b11
  } parMode_e;

  localparam int WORD_W = 9;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;
    logic parLatch;
    logic commit;
  } ctrlStrobe_t;

  typedef struct packed {
    logic              frmErr;
    logic              parErr;
    logic [WORD_W-1:0] data;
  } rxEntry_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        lineBit,
  input  logic        nineBit,
  input  logic        parityOn,
  output ctrlStrobe_t strobe
);
  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] MIDM1 = CNT_W'(TICKS_PER_BIT / 2 - 1);

  rxState_e         state;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       bitCnt;
  logic [3:0]       lastBit;

  assign lastBit = nineBit ? 4'd8 : 4'd7;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitCnt <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (!lineBit) state <= ST_START;
        end
        ST_START: begin
          if (cnt == MIDM1) begin
            cnt    <= '0;
            bitCnt <= '0;
            state  <= lineBit ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == LAST) begin
            cnt    <= '0;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == lastBit)
              state <= (parityOn && !nineBit) ? ST_PAR : ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.shift    = tick && (state == ST_DATA) && (cnt == LAST);
    strobe.parLatch = tick && (state == ST_PAR) && (cnt == LAST);
    strobe.commit   = tick && (state == ST_STOP) && (cnt == LAST);
  end

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        lineBit,
  input  logic        nineBit,
  input  logic        parityOn,
  input  logic [1:0]  parityMode,
  input  logic        addrOnly,
  input  logic        full,
  input  logic        ovrClear,
  output logic        wrEn,
  output rxEntry_t    wrEntry,
  output logic        overrun
);
  logic [WORD_W-1:0] shiftReg;
  logic              parBit;
  logic              accept;
  logic              oddSense;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strobe.shift)    shiftReg <= {lineBit, shiftReg[WORD_W-1:1]};
      if (strobe.parLatch) parBit   <= lineBit;
    end
  end

  assign oddSense = (parityMode == PAR_ODD);

  always_comb begin
    wrEntry.data   = nineBit ? shiftReg : {1'b0, shiftReg[WORD_W-1:1]};
    wrEntry.parErr = parityOn && !nineBit &&
                     ((^shiftReg[WORD_W-1:1] ^ parBit) != oddSense);
    wrEntry.frmErr = !lineBit;
  end

  assign accept = !(nineBit && addrOnly && !shiftReg[WORD_W-1]);
  assign wrEn   = strobe.commit && accept && !full;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            overrun <= 1'b0;
    else if (strobe.commit && accept && full) overrun <= 1'b1;
    else if (ovrClear)                    overrun <= 1'b0;
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  rxEntry_t         wrEntry,
  input  logic             popReq,
  output rxEntry_t         head,
  output logic [LVL_W-1:0] count,
  output logic             full
);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  rxEntry_t         mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             rdEn;

  assign full = (count == LVL_W'(DEPTH));
  assign rdEn = popReq && (count != '0);
  assign head = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wrEn) begin
        mem[wrPtr] <= wrEntry;
        wrPtr      <= (wrPtr == PTR_MAX) ? '0 : wrPtr + 1'b1;
      end
      if (rdEn) rdPtr <= (rdPtr == PTR_MAX) ? '0 : rdPtr + 1'b1;
      case ({wrEn, rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DEPTH         = 4,
  parameter int RTS_MARK      = 3,
  parameter int SYNC_N        = 2,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             rxIn,
  input  logic             txLoop,
  input  logic             loopEn,
  input  logic             nineBit,
  input  logic [1:0]       parityMode,
  input  logic             addrOnly,
  input  logic             popReq,
  input  logic             ovrClear,
  output logic [8:0]       rdData,
  output logic             rdParErr,
  output logic             rdFrmErr,
  output logic             rdValid,
  output logic [LVL_W-1:0] level,
  output logic             overrun,
  output logic             sendReq
);
  logic [SYNC_N-1:0] syncQ;
  logic              rawLine;
  logic              lineBit;
  logic              parityOn;
  ctrlStrobe_t       strobe;
  logic              wrEn;
  rxEntry_t          wrEntry;
  rxEntry_t          head;
  logic              full;

  assign rawLine = loopEn ? txLoop : rxIn;

  generate
    if (SYNC_N > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_N-2:0], rawLine};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= rawLine;
      end
    end
  endgenerate

  assign lineBit  = syncQ[SYNC_N-1];
  assign parityOn = (parityMode == PAR_EVEN) || (parityMode == PAR_ODD);

  uart_rx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(sampleTick), .lineBit(lineBit),
    .nineBit(nineBit), .parityOn(parityOn), .strobe(strobe)
  );

  uart_rx_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineBit(lineBit),
    .nineBit(nineBit), .parityOn(parityOn), .parityMode(parityMode),
    .addrOnly(addrOnly), .full(full), .ovrClear(ovrClear),
    .wrEn(wrEn), .wrEntry(wrEntry), .overrun(overrun)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrEntry(wrEntry),
    .popReq(popReq), .head(head), .count(level), .full(full)
  );

  assign rdData   = head.data;
  assign rdParErr = head.parErr;
  assign rdFrmErr = head.frmErr;
  assign rdValid  = (level != '0);
  assign sendReq  = (level < LVL_W'(RTS_MARK));

endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [LVL_W-1:0] level,
  input logic             rdValid,
  input logic             overrun,
  input logic             ovrClear,
  input logic             wrEn,
  input logic             wrAddrBit,
  input logic             wrParErr,
  input logic             nineBit,
  input logic             addrOnly,
  input logic             sendReq
);
  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rstN)
    int'(level) <= DEPTH); // R7
  AST_VALID_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    rdValid == (level != '0)); // R7
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (int'(level) == int'($past(level))) || (int'(level) == int'($past(level)) + 1) ||
    (int'(level) + 1 == int'($past(level)))); // R7
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !ovrClear |=> overrun); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> int'(level) < DEPTH); // R8
  AST_ADDR_FILTER: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && nineBit && addrOnly |-> wrAddrBit); // R6
  AST_PAR_NINE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && nineBit |-> !wrParErr); // R3
  AST_RTS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    int'(level) == DEPTH |-> !sendReq); // R9
endmodule

bind uart_rx_top uart_rx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rstN(rstN), .level(level), .rdValid(rdValid),
  .overrun(overrun), .ovrClear(ovrClear), .wrEn(wrEn),
  .wrAddrBit(wrEntry.data[8]), .wrParErr(wrEntry.parErr),
  .nineBit(nineBit), .addrOnly(addrOnly), .sendReq(sendReq)
);

// File: tb/uart_rx_top_tb.sv
`timescale 1ns/1ps
module uart_rx_top_tb_top;
  logic       clk = 0;
  logic       rstN = 0;
  logic       sampleTick = 0;
  logic       lineVal = 1;
  logic       loopMode = 0;
  logic       loopEn = 0;
  logic       nineBit = 0;
  logic [1:0] parityMode = 2'b00;
  logic       addrOnly = 0;
  logic       popReq = 0;
  logic       ovrClear = 0;
  logic       rxIn, txLoop;
  logic [8:0] rdData;
  logic       rdParErr, rdFrmErr, rdValid, overrun, sendReq;
  logic [2:0] level;
  int total = 0;
  int bad = 0;

  assign rxIn   = loopMode ? 1'b0 : lineVal;
  assign txLoop = loopMode ? lineVal : 1'b1;

  always #4 clk = ~clk;

  uart_rx_top dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxIn(rxIn),
    .txLoop(txLoop), .loopEn(loopEn), .nineBit(nineBit),
    .parityMode(parityMode), .addrOnly(addrOnly), .popReq(popReq),
    .ovrClear(ovrClear), .rdData(rdData), .rdParErr(rdParErr),
    .rdFrmErr(rdFrmErr), .rdValid(rdValid), .level(level),
    .overrun(overrun), .sendReq(sendReq)
  );

  typedef struct packed {
    logic       nine;
    logic [1:0] pm;
    logic       addr;
    logic [8:0] data;
    logic       pb;
    logic       sb;
    logic       expStore;
    logic [8:0] expData;
    logic       expPar;
    logic       expFrm;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 2'd0, 1'b0, 9'h0A5, 1'b0, 1'b1, 1'b1, 9'h0A5, 1'b0, 1'b0}, // R2
    '{1'b0, 2'd1, 1'b0, 9'h003, 1'b0, 1'b1, 1'b1, 9'h003, 1'b0, 1'b0}, // R4 even ok
    '{1'b0, 2'd1, 1'b0, 9'h007, 1'b0, 1'b1, 1'b1, 9'h007, 1'b1, 1'b0}, // R4 even bad
    '{1'b0, 2'd2, 1'b0, 9'h007, 1'b0, 1'b1, 1'b1, 9'h007, 1'b0, 1'b0}, // R4 odd ok
    '{1'b0, 2'd2, 1'b0, 9'h007, 1'b1, 1'b1, 1'b1, 9'h007, 1'b1, 1'b0}, // R4 odd bad
    '{1'b0, 2'd0, 1'b0, 9'h03C, 1'b0, 1'b0, 1'b1, 9'h03C, 1'b0, 1'b1}, // R5
    '{1'b1, 2'd0, 1'b0, 9'h0F5, 1'b0, 1'b1, 1'b1, 9'h0F5, 1'b0, 1'b0}, // R3
    '{1'b1, 2'd0, 1'b1, 9'h0F5, 1'b0, 1'b1, 1'b0, 9'h000, 1'b0, 1'b0}, // R6 drop
    '{1'b1, 2'd0, 1'b1, 9'h1C3, 1'b0, 1'b1, 1'b1, 9'h1C3, 1'b0, 1'b0}, // R6 keep
    '{1'b1, 2'd1, 1'b0, 9'h101, 1'b0, 1'b1, 1'b1, 9'h101, 1'b0, 1'b0}, // R3 no parity
    '{1'b0, 2'd3, 1'b0, 9'h0FF, 1'b0, 1'b1, 1'b1, 9'h0FF, 1'b0, 1'b0}  // R4 mode 11
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tickOnce();
    repeat (3) @(negedge clk);
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    lineVal = b;
    repeat (16) tickOnce();
  endtask

  task automatic sendFrame(input logic [8:0] d, input logic pb, input logic sb);
    sendBit(1'b0);
    for (int i = 0; i < (nineBit ? 9 : 8); i++) sendBit(d[i]);
    if (!nineBit && (parityMode == 2'd1 || parityMode == 2'd2)) sendBit(pb);
    sendBit(sb);
    lineVal = 1'b1;
    repeat (20) tickOnce();
  endtask

  task automatic popOne();
    @(negedge clk); popReq = 1'b1;
    @(negedge clk); popReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 reset level", int'(level), 0);
    check("R7 reset rdValid", int'(rdValid), 0);
    check("R8 reset overrun", int'(overrun), 0);
    check("R9 reset sendReq", int'(sendReq), 1);

    for (int v = 0; v < NVEC; v++) begin
      nineBit = VEC[v].nine; parityMode = VEC[v].pm; addrOnly = VEC[v].addr;
      sendFrame(VEC[v].data, VEC[v].pb, VEC[v].sb);
      check($sformatf("R2/R3/R6 vec%0d stored", v), int'(rdValid), int'(VEC[v].expStore));
      if (VEC[v].expStore) begin
        check($sformatf("R2/R3 vec%0d data", v), int'(rdData), int'(VEC[v].expData));
        check($sformatf("R4 vec%0d parErr", v), int'(rdParErr), int'(VEC[v].expPar));
        check($sformatf("R5 vec%0d frmErr", v), int'(rdFrmErr), int'(VEC[v].expFrm));
        popOne();
      end
      check($sformatf("R7 vec%0d level after pop", v), int'(level), 0);
    end

    // R1: short low pulse must not start a character
    nineBit = 0; parityMode = 2'd0; addrOnly = 0;
    lineVal = 1'b0; repeat (5) tickOnce();
    lineVal = 1'b1; repeat (40) tickOnce();
    check("R1 glitch rejected", int'(level), 0);
    sendFrame(9'h055, 1'b0, 1'b1);
    check("R1 recovery data", int'(rdData), 'h55);
    popOne();

    // R7/R8/R9: fill, overrun, order
    sendFrame(9'h011, 1'b0, 1'b1);
    check("R9 level1 sendReq", int'(sendReq), 1);
    sendFrame(9'h022, 1'b0, 1'b1);
    check("R9 level2 sendReq", int'(sendReq), 1);
    sendFrame(9'h033, 1'b0, 1'b1);
    check("R9 level3 sendReq", int'(sendReq), 0);
    sendFrame(9'h044, 1'b0, 1'b1);
    check("R7 level4", int'(level), 4);
    check("R8 no overrun yet", int'(overrun), 0);
    sendFrame(9'h099, 1'b0, 1'b1);
    check("R8 overrun set", int'(overrun), 1);
    check("R8 level stays 4", int'(level), 4);
    repeat (30) tickOnce();
    check("R8 overrun sticky", int'(overrun), 1);
    check("R7 order 1", int'(rdData), 'h11); popOne();
    check("R7 order 2", int'(rdData), 'h22); popOne();
    check("R9 level2 after pops", int'(sendReq), 1);
    check("R7 order 3", int'(rdData), 'h33); popOne();
    check("R7 order 4", int'(rdData), 'h44); popOne();
    check("R7 empty", int'(rdValid), 0);
    @(negedge clk); ovrClear = 1'b1;
    @(negedge clk); ovrClear = 1'b0;
    check("R8 overrun cleared", int'(overrun), 0);

    // R10: loopback, rxIn held low and ignored
    @(negedge clk); loopEn = 1'b1; loopMode = 1'b1;
    repeat (40) tickOnce();
    check("R10 rxIn ignored", int'(level), 0);
    sendFrame(9'h06B, 1'b0, 1'b1);
    check("R10 loop data", int'(rdData), 'h6B);
    check("R10 loop level", int'(level), 1);
    popOne();
    loopMode = 1'b0;
    @(negedge clk); loopEn = 1'b0;
    repeat (20) tickOnce();
    sendFrame(9'h0C6, 1'b0, 1'b1);
    check("R10 external path data", int'(rdData), 'hC6);
    popOne();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule